// File: doc/BRIEF.md
# Reset and Wake Cause Recorder

This block keeps the record of why a small processor core last restarted or left sleep, and works out where execution continues. Single-cycle event pulses from the power monitor, the external reset pin, the watchdog, the interrupt wake logic, the reset opcode and the hardware stack each change their own group of flags. All other flags keep their value, so firmware can still read causes left there by earlier events. Most flags are active-low: an event pulls a flag to 0, and firmware writes it back to 1 after it has read it.

The flags sit in two byte-wide views. The power view holds the stack overflow and underflow flags and the pin, opcode, power-on and brown-out flags. The core view holds the time-out and power-down flags. Every event is also turned into a registered restart result. A reset-type event restarts at the reset vector. A wake from sleep resumes at the next instruction. An interrupt wake with interrupts globally enabled asks for a stack push of the next address and then goes to the interrupt vector.

Top module: `rst_cause_rec`

## Requirements
- R1: While `rst` is high and on the edge after it, `pwr_flags_o` reads 8'h0D and `core_flags_o` reads 8'h18. `restart_vld_o` and `push_req_o` read 0 and `restart_addr_o` reads the reset vector. Power view bit layout: 7 overflow, 6 underflow, 5:4 unused, 3 pin-reset flag, 2 opcode-reset flag, 1 power-on flag, 0 brown-out flag. Core view: bit 4 time-out, bit 3 power-down, all other bits unused.
- R2: A power-on pulse clears overflow, underflow and power-on, and sets the pin, opcode, brown-out, time-out and power-down flags. Both views then read 8'h0D and 8'h18. It overrides every other event in the same cycle.
- R3: A brown-out pulse without power-on clears overflow, underflow and brown-out, and sets the pin, opcode, time-out and power-down flags. The power-on flag keeps its value. It overrides all other events except power-on.
- R4: A watchdog time-out while awake clears only the time-out flag and restarts at the reset vector.
- R5: A watchdog wake from sleep clears the time-out and power-down flags and resumes at pc_i+1, modulo 2^PC_W.
- R6: An interrupt wake sets time-out and clears power-down. With `gie_i` at 0 it resumes at pc_i+1. With `gie_i` at 1 it raises `push_req_o` with `push_addr_o` = pc_i+1 and restarts at the interrupt vector (4).
- R7: A pin reset while awake clears only the pin-reset flag. A pin reset during sleep also sets time-out and clears power-down. Both restart at the reset vector.
- R8: The reset opcode clears only the opcode-reset flag and restarts at the reset vector.
- R9: A stack overflow sets bit 7 and an underflow sets bit 6 whatever the value of `stk_rst_en`. They restart at the reset vector only when `stk_rst_en` is 1. Otherwise there is no restart pulse and the restart address is held.
- R10: Events below brown-out that arrive in the same cycle all apply. A flag that one event sets and another clears ends at 0. Any reset-type event takes the restart over a wake.
- R11: With `sw_we` high and no event, `sw_sel`=0 loads the power view and `sw_sel`=1 loads the core view from `sw_wdata`. Unused bits stay 0. A write in a cycle that carries any event is ignored.
- R12: Flag and restart outputs change on the clock edge that samples the event. `restart_vld_o` and `push_req_o` are single-cycle pulses. With no event and no write, nothing changes except that the pulses drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the power-on image |
| ev_por | input | 1 | Power-on pulse |
| ev_bor | input | 1 | Brown-out pulse |
| ev_pin_run | input | 1 | External pin reset while awake |
| ev_pin_slp | input | 1 | External pin reset during sleep |
| ev_wdt_run | input | 1 | Watchdog time-out while awake |
| ev_wdt_slp | input | 1 | Watchdog wake from sleep |
| ev_irq_wake | input | 1 | Interrupt wake from sleep |
| ev_rst_op | input | 1 | Reset opcode executed |
| ev_stk_ovf | input | 1 | Stack overflow |
| ev_stk_unf | input | 1 | Stack underflow |
| stk_rst_en | input | 1 | Stack faults force a restart |
| gie_i | input | 1 | Global interrupt enable |
| pc_i | input | PC_W | Current program counter |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0 selects power view, 1 selects core view |
| sw_wdata | input | 8 | Software write data |
| pwr_flags_o | output | 8 | Power view of the flags |
| core_flags_o | output | 8 | Core view of the flags |
| restart_vld_o | output | 1 | Restart pulse |
| restart_addr_o | output | PC_W | Restart address |
| push_req_o | output | 1 | Stack push request pulse |
| push_addr_o | output | PC_W | Address to push |

## Verification
On every cycle the assertions check the power-on and brown-out images, the forced restart to the reset vector, the tie between a push request and the interrupt vector, the stack flag capture and the hold of all flags on idle cycles. Some behaviours show only in the bench's scenarios, because they depend on several inputs together: the clear-wins merge of simultaneous wakes, the pc+1 wrap, a write dropped because an event shares its cycle, and the masking of unused bits. The bench also runs long random event mixes against its own model, with each previously cleared flag re-armed by software.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    typedef struct packed {
        logic stk_ovf;
        logic stk_unf;
        logic pin_n;
        logic op_n;
        logic por_n;
        logic bor_n;
        logic timeout_n;
        logic pwrdown_n;
    } cause_t;

    typedef struct packed {
        logic por;
        logic bor;
        logic pin_run;
        logic pin_slp;
        logic wdt_run;
        logic wdt_slp;
        logic irq_wake;
        logic rst_op;
        logic stk_ovf;
        logic stk_unf;
    } evt_t;

    localparam cause_t POR_IMAGE = '{stk_ovf: 1'b0, stk_unf: 1'b0, pin_n: 1'b1,
                                      op_n: 1'b1, por_n: 1'b0, bor_n: 1'b1,
                                      timeout_n: 1'b1, pwrdown_n: 1'b1};

    function automatic logic [7:0] pwr_view(cause_t c);
        return {c.stk_ovf, c.stk_unf, 2'b00, c.pin_n, c.op_n, c.por_n, c.bor_n};
    endfunction

    function automatic logic [7:0] core_view(cause_t c);
        return {3'b000, c.timeout_n, c.pwrdown_n, 3'b000};
    endfunction

    function automatic cause_t load_pwr(cause_t c, logic [7:0] d);
        cause_t r;
        r = c;
        r.stk_ovf = d[7];
        r.stk_unf = d[6];
        r.pin_n   = d[3];
        r.op_n    = d[2];
        r.por_n   = d[1];
        r.bor_n   = d[0];
        return r;
    endfunction

    function automatic cause_t load_core(cause_t c, logic [7:0] d);
        cause_t r;
        r = c;
        r.timeout_n = d[4];
        r.pwrdown_n = d[3];
        return r;
    endfunction

endpackage

// File: rtl/rcr_evt_decode.sv
module rcr_evt_decode
    import rcr_pkg::*;
(
    input  evt_t   ev,
    input  logic   stk_rst_en,
    output cause_t set_m,
    output cause_t clr_m,
    output logic   any_evt,
    output logic   hard_rst,
    output logic   wake
);
    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (ev.por) begin
            set_m.pin_n     = 1'b1;
            set_m.op_n      = 1'b1;
            set_m.bor_n     = 1'b1;
            set_m.timeout_n = 1'b1;
            set_m.pwrdown_n = 1'b1;
            clr_m.stk_ovf   = 1'b1;
            clr_m.stk_unf   = 1'b1;
            clr_m.por_n     = 1'b1;
        end else if (ev.bor) begin
            set_m.pin_n     = 1'b1;
            set_m.op_n      = 1'b1;
            set_m.timeout_n = 1'b1;
            set_m.pwrdown_n = 1'b1;
            clr_m.stk_ovf   = 1'b1;
            clr_m.stk_unf   = 1'b1;
            clr_m.bor_n     = 1'b1;
        end else begin
            set_m.stk_ovf   = ev.stk_ovf;
            set_m.stk_unf   = ev.stk_unf;
            set_m.timeout_n = ev.irq_wake | ev.pin_slp;
            clr_m.timeout_n = ev.wdt_run | ev.wdt_slp;
            clr_m.pwrdown_n = ev.wdt_slp | ev.irq_wake | ev.pin_slp;
            clr_m.pin_n     = ev.pin_run | ev.pin_slp;
            clr_m.op_n      = ev.rst_op;
        end
    end

    assign any_evt  = |ev;
    assign hard_rst = ev.por | ev.bor | ev.pin_run | ev.pin_slp | ev.wdt_run |
                      ev.rst_op | (stk_rst_en & (ev.stk_ovf | ev.stk_unf));
    assign wake     = ev.wdt_slp | ev.irq_wake;
endmodule

// File: rtl/rcr_flag_bank.sv
module rcr_flag_bank
    import rcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cause_t     set_m,
    input  cause_t     clr_m,
    input  logic       any_evt,
    input  logic       sw_we,
    input  logic       sw_sel,
    input  logic [7:0] sw_wdata,
    output cause_t     flags
);
    cause_t nxt;

    always_comb begin
        nxt = flags;
        if (any_evt)
            nxt = cause_t'((flags | set_m) & ~clr_m);
        else if (sw_we)
            nxt = sw_sel ? load_core(flags, sw_wdata) : load_pwr(flags, sw_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= POR_IMAGE;
        else     flags <= nxt;
    end
endmodule

// File: rtl/rcr_restart.sv
module rcr_restart #(
    parameter int unsigned PC_W      = 15,
    parameter int unsigned RESET_VEC = 0,
    parameter int unsigned INT_VEC   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hard_rst,
    input  logic            wake,
    input  logic            irq_wake,
    input  logic            gie,
    input  logic [PC_W-1:0] pc,
    output logic            vld,
    output logic [PC_W-1:0] addr,
    output logic            push,
    output logic [PC_W-1:0] push_addr
);
    localparam logic [PC_W-1:0] RVEC = PC_W'(RESET_VEC);
    localparam logic [PC_W-1:0] IVEC = PC_W'(INT_VEC);

    logic [PC_W-1:0] next_pc;
    assign next_pc = pc + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld       <= 1'b0;
            addr      <= RVEC;
            push      <= 1'b0;
            push_addr <= '0;
        end else begin
            vld  <= hard_rst | wake;
            push <= 1'b0;
            if (hard_rst) begin
                addr <= RVEC;
            end else if (irq_wake && gie) begin
                addr      <= IVEC;
                push      <= 1'b1;
                push_addr <= next_pc;
            end else if (wake) begin
                addr <= next_pc;
            end
        end
    end
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rcr_pkg::*;
#(
    parameter int unsigned PC_W      = 15,
    parameter int unsigned RESET_VEC = 0,
    parameter int unsigned INT_VEC   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ev_por,
    input  logic            ev_bor,
    input  logic            ev_pin_run,
    input  logic            ev_pin_slp,
    input  logic            ev_wdt_run,
    input  logic            ev_wdt_slp,
    input  logic            ev_irq_wake,
    input  logic            ev_rst_op,
    input  logic            ev_stk_ovf,
    input  logic            ev_stk_unf,
    input  logic            stk_rst_en,
    input  logic            gie_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            sw_we,
    input  logic            sw_sel,
    input  logic [7:0]      sw_wdata,
    output logic [7:0]      pwr_flags_o,
    output logic [7:0]      core_flags_o,
    output logic            restart_vld_o,
    output logic [PC_W-1:0] restart_addr_o,
    output logic            push_req_o,
    output logic [PC_W-1:0] push_addr_o
);
    evt_t   ev;
    cause_t set_m, clr_m, flags;
    logic   any_evt, hard_rst, wake;

    assign ev = '{por: ev_por, bor: ev_bor, pin_run: ev_pin_run, pin_slp: ev_pin_slp,
                  wdt_run: ev_wdt_run, wdt_slp: ev_wdt_slp, irq_wake: ev_irq_wake,
                  rst_op: ev_rst_op, stk_ovf: ev_stk_ovf, stk_unf: ev_stk_unf};

    rcr_evt_decode u_dec (
        .ev(ev), .stk_rst_en(stk_rst_en), .set_m(set_m), .clr_m(clr_m),
        .any_evt(any_evt), .hard_rst(hard_rst), .wake(wake)
    );

    rcr_flag_bank u_flags (
        .clk(clk), .rst(rst), .set_m(set_m), .clr_m(clr_m), .any_evt(any_evt),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .flags(flags)
    );

    rcr_restart #(.PC_W(PC_W), .RESET_VEC(RESET_VEC), .INT_VEC(INT_VEC)) u_rs (
        .clk(clk), .rst(rst), .hard_rst(hard_rst), .wake(wake), .irq_wake(ev_irq_wake),
        .gie(gie_i), .pc(pc_i), .vld(restart_vld_o), .addr(restart_addr_o),
        .push(push_req_o), .push_addr(push_addr_o)
    );

    assign pwr_flags_o  = pwr_view(flags);
    assign core_flags_o = core_view(flags);
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
    parameter int unsigned PC_W      = 15,
    parameter int unsigned RESET_VEC = 0,
    parameter int unsigned INT_VEC   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            ev_por,
    input logic            ev_bor,
    input logic            ev_pin_run,
    input logic            ev_pin_slp,
    input logic            ev_wdt_run,
    input logic            ev_wdt_slp,
    input logic            ev_irq_wake,
    input logic            ev_rst_op,
    input logic            ev_stk_ovf,
    input logic            ev_stk_unf,
    input logic            stk_rst_en,
    input logic            gie_i,
    input logic [PC_W-1:0] pc_i,
    input logic            sw_we,
    input logic            sw_sel,
    input logic [7:0]      sw_wdata,
    input logic [7:0]      pwr_flags_o,
    input logic [7:0]      core_flags_o,
    input logic            restart_vld_o,
    input logic [PC_W-1:0] restart_addr_o,
    input logic            push_req_o,
    input logic [PC_W-1:0] push_addr_o
);
    logic any_ev, rst_kind;
    assign any_ev = ev_por | ev_bor | ev_pin_run | ev_pin_slp | ev_wdt_run | ev_wdt_slp |
                    ev_irq_wake | ev_rst_op | ev_stk_ovf | ev_stk_unf;
    assign rst_kind = ev_por | ev_bor | ev_pin_run | ev_pin_slp | ev_wdt_run | ev_rst_op |
                      (stk_rst_en & (ev_stk_ovf | ev_stk_unf));

    // R2
    a_r2_por_image: assert property (@(posedge clk) disable iff (rst)
        ev_por |=> (pwr_flags_o == 8'h0D && core_flags_o == 8'h18));

    // R3
    a_r3_bor_image: assert property (@(posedge clk) disable iff (rst)
        (ev_bor && !ev_por) |=> (pwr_flags_o[7:6] == 2'b00 && pwr_flags_o[0] == 1'b0 &&
                                 pwr_flags_o[3:2] == 2'b11 && core_flags_o == 8'h18 &&
                                 pwr_flags_o[1] == $past(pwr_flags_o[1])));

    // R4, R7, R8, R10
    a_r10_reset_wins: assert property (@(posedge clk) disable iff (rst)
        rst_kind |=> (restart_vld_o && restart_addr_o == PC_W'(RESET_VEC) && !push_req_o));

    // R6
    a_r6_push_vector: assert property (@(posedge clk) disable iff (rst)
        push_req_o |-> (restart_vld_o && restart_addr_o == PC_W'(INT_VEC)));

    // R9
    a_r9_stack_flags: assert property (@(posedge clk) disable iff (rst)
        (!ev_por && !ev_bor && ev_stk_ovf && ev_stk_unf) |=> (pwr_flags_o[7:6] == 2'b11));

    // R12
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!any_ev && !sw_we) |=> ($stable(pwr_flags_o) && $stable(core_flags_o) &&
                                 $stable(restart_addr_o) && !restart_vld_o && !push_req_o));

    // R12
    a_r12_push_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !ev_irq_wake |=> $stable(push_addr_o));

    logic unused_ok;
    assign unused_ok = ^{gie_i, pc_i, sw_sel, sw_wdata};
endmodule

bind rst_cause_rec rcr_checker #(.PC_W(PC_W), .RESET_VEC(RESET_VEC), .INT_VEC(INT_VEC)) u_chk (.*);

// File: tb/sim_rst_cause_rec.sv
module sim_rst_cause_rec;
    localparam int PC_W = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_por = 0, ev_bor = 0, ev_pin_run = 0, ev_pin_slp = 0, ev_wdt_run = 0;
    logic ev_wdt_slp = 0, ev_irq_wake = 0, ev_rst_op = 0, ev_stk_ovf = 0, ev_stk_unf = 0;
    logic stk_rst_en = 0, gie_i = 0, sw_we = 0, sw_sel = 0;
    logic [PC_W-1:0] pc_i = '0;
    logic [7:0] sw_wdata = '0;
    logic [7:0] pwr_flags_o, core_flags_o;
    logic restart_vld_o, push_req_o;
    logic [PC_W-1:0] restart_addr_o, push_addr_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] e_pwr, e_core;
    logic e_vld, e_push;
    logic [PC_W-1:0] e_addr, e_paddr;

    always #10 clk = ~clk;

    rst_cause_rec #(.PC_W(PC_W)) u0 (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic any_event();
        return ev_por | ev_bor | ev_pin_run | ev_pin_slp | ev_wdt_run | ev_wdt_slp |
               ev_irq_wake | ev_rst_op | ev_stk_ovf | ev_stk_unf;
    endfunction

    task automatic predict();
        logic rk;
        e_vld  = 0;
        e_push = 0;
        if (ev_por) begin
            e_pwr = 8'h0D; e_core = 8'h18;
        end else if (ev_bor) begin
            e_pwr = {6'b000011, e_pwr[1], 1'b0}; e_core = 8'h18;
        end else if (any_event()) begin
            if (ev_stk_ovf) e_pwr[7] = 1;
            if (ev_stk_unf) e_pwr[6] = 1;
            if (ev_irq_wake || ev_pin_slp) e_core[4] = 1;
            if (ev_wdt_run || ev_wdt_slp) e_core[4] = 0;
            if (ev_wdt_slp || ev_irq_wake || ev_pin_slp) e_core[3] = 0;
            if (ev_pin_run || ev_pin_slp) e_pwr[3] = 0;
            if (ev_rst_op) e_pwr[2] = 0;
        end else if (sw_we) begin
            if (sw_sel) e_core = sw_wdata & 8'h18;
            else        e_pwr  = sw_wdata & 8'hCF;
        end
        rk = ev_por | ev_bor | ev_pin_run | ev_pin_slp | ev_wdt_run | ev_rst_op |
             (stk_rst_en & (ev_stk_ovf | ev_stk_unf));
        if (rk) begin
            e_vld = 1; e_addr = '0;
        end else if (ev_irq_wake && gie_i) begin
            e_vld = 1; e_addr = 15'd4; e_push = 1; e_paddr = pc_i + 1'b1;
        end else if (ev_wdt_slp || ev_irq_wake) begin
            e_vld = 1; e_addr = pc_i + 1'b1;
        end
    endtask

    task automatic clear_inputs();
        {ev_por, ev_bor, ev_pin_run, ev_pin_slp, ev_wdt_run} = '0;
        {ev_wdt_slp, ev_irq_wake, ev_rst_op, ev_stk_ovf, ev_stk_unf} = '0;
        sw_we = 0;
    endtask

    task automatic compare(string tag);
        chk(tag, "pwr", 32'(pwr_flags_o), 32'(e_pwr));
        chk(tag, "core", 32'(core_flags_o), 32'(e_core));
        chk(tag, "vld", 32'(restart_vld_o), 32'(e_vld));
        chk(tag, "addr", 32'(restart_addr_o), 32'(e_addr));
        chk(tag, "push", 32'(push_req_o), 32'(e_push));
        if (e_push) chk(tag, "push_addr", 32'(push_addr_o), 32'(e_paddr));
    endtask

    task automatic step(string tag);
        predict();
        @(posedge clk); #1;
        compare(tag);
        clear_inputs();
    endtask

    task automatic rearm();
        sw_we = 1; sw_sel = 0; sw_wdata = {2'b00, 6'b001111}; step("R11");
        sw_we = 1; sw_sel = 1; sw_wdata = 8'h18; step("R11");
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        string tag;
        void'($urandom(32'h0C0FFEE5));
        e_pwr = 8'h0D; e_core = 8'h18; e_vld = 0; e_push = 0; e_addr = '0; e_paddr = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");
        rst = 0;
        step("R1");

        ev_wdt_run = 1; step("R4");
        rearm();
        pc_i = 15'h1234; ev_wdt_slp = 1; step("R5");
        rearm();
        pc_i = 15'h7FFF; gie_i = 0; ev_irq_wake = 1; step("R6");
        pc_i = 15'h0100; gie_i = 1; ev_irq_wake = 1; step("R6");
        step("R12");
        ev_pin_run = 1; step("R7");
        rearm();
        ev_pin_slp = 1; step("R7");
        ev_rst_op = 1; step("R8");
        stk_rst_en = 0; ev_stk_ovf = 1; step("R9");
        stk_rst_en = 1; ev_stk_unf = 1; step("R9");
        ev_bor = 1; ev_wdt_run = 1; step("R3");
        ev_por = 1; ev_bor = 1; ev_rst_op = 1; step("R2");
        rearm();
        ev_wdt_slp = 1; ev_irq_wake = 1; gie_i = 1; pc_i = 15'h0042; step("R10");
        ev_irq_wake = 1; ev_rst_op = 1; step("R10");
        sw_we = 1; sw_sel = 0; sw_wdata = 8'hFF; step("R11");
        sw_we = 1; sw_sel = 1; sw_wdata = 8'hFF; step("R11");
        sw_we = 1; sw_sel = 1; sw_wdata = 8'h00; ev_stk_ovf = 1; stk_rst_en = 0; step("R11");
        step("R12");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            ev_por      = ($urandom % 64) == 0;
            ev_bor      = ($urandom % 40) == 0;
            ev_pin_run  = ($urandom % 12) == 0;
            ev_pin_slp  = ($urandom % 12) == 0;
            ev_wdt_run  = ($urandom % 12) == 0;
            ev_wdt_slp  = ($urandom % 12) == 0;
            ev_irq_wake = ($urandom % 10) == 0;
            ev_rst_op   = ($urandom % 12) == 0;
            ev_stk_ovf  = ($urandom % 14) == 0;
            ev_stk_unf  = ($urandom % 14) == 0;
            stk_rst_en  = r[0];
            gie_i       = r[1];
            sw_we       = r[2];
            sw_sel      = r[3];
            sw_wdata    = r[11:4];
            pc_i        = r[26:12];
            if (ev_por) tag = "R2";
            else if (ev_bor) tag = "R3";
            else if (any_event()) tag = "R10";
            else if (sw_we) tag = "R11";
            else tag = "R12";
            step(tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule